// File: doc/BRIEF.md
# Multiplexed-Address Byte-Wide EPROM Reader

This block fetches single bytes from an external parallel EPROM through one shared 8-bit data bus. The bus is modelled as split wires: a driven value, an output enable and a received value. A read request carries a 24-bit byte address. The block pulls the active-low ROM select down and sends the address one byte at a time. Each byte is captured by an external octal latch, strobed by its own address-latch enable. The block then releases the bus for one turnaround clock and waits a programmable access time. At the end of that wait it samples the byte the EPROM returns and hands it back with a one-cycle done pulse.

A strap pin is sampled while reset is held. When the strap reads low, the address-16 pin becomes a third latch enable and a third address byte (bits 23:16) goes out on the bus. When it reads high, only two bytes are latched, and address bits 16 and 17 drive their own pins directly. An odd-parity line travels with the bus. The block generates parity on address bytes, and it can check parity on the returned byte when checking is enabled.

The sequencer states are IDLE, LAT0, HLD0, LAT1, HLD1, LAT2, HLD2, TURN, WAIT and DONE. The transitions are as follows:
- IDLE→LAT0 when a request is accepted.
- LAT0→HLD0, HLD0→LAT1 and LAT1→HLD1 always.
- HLD1→LAT2 in three-latch mode, or HLD1→TURN in two-latch mode.
- LAT2→HLD2 and HLD2→TURN always.
- TURN→WAIT always.
- WAIT→DONE once the wait counter equals the access time.
- DONE→IDLE always.

Top module: `eprom_mux_reader`

## Requirements
- R1: `rom_sel_n` is low in every cycle from the first address phase through the last wait cycle, and high in the DONE cycle and while idle.
- R2: Address bits 7:0 are driven on `bus_dout` with `bus_oe` high while `ale_lo` is high for exactly one clock. The same byte stays driven for the following clock with `ale_lo` low.
- R3: Address bits 15:8 follow in the same way with `ale_mid`: one clock high, then one hold clock with the byte unchanged.
- R4: If `strap_n` is low during reset, `a16_ale` acts as a third enable. It pulses once, with bits 23:16 on the bus, after the bits 15:8 phase. The done pulse appears `acc_wait`+9 clocks after the accepting edge.
- R5: If `strap_n` is high during reset, only two bytes are latched. `a16_ale` carries address bit 16 and never pulses as an enable. The done pulse appears `acc_wait`+7 clocks after the accepting edge.
- R6: After the last hold clock, `bus_oe` is low for one turnaround clock plus `acc_wait`+1 wait clocks. Data is sampled at the end of the last wait clock. `bus_oe` only rises after a cycle with `rom_sel_n` high.
- R7: `a17_pin` carries address bit 17 throughout an access in both modes.
- R8: Whenever `bus_oe` is high, `bus_par_out` makes the total count of ones across `bus_dout` and `bus_par_out` odd.
- R9: With `par_en` high, `rd_perr` is 1 exactly when `bus_din` and `bus_par_in` together hold an even number of ones. With `par_en` low, `rd_perr` is 0.
- R10: `req_ready` is high only in IDLE, and a request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `rd_done` is a one-cycle pulse, and `rd_data` and `rd_perr` are valid with it.
- R11: `req_valid` raised while an access is in progress starts no further address phases and does not alter the returned byte.
- R12: After reset, `rom_sel_n` is high, all enables and `bus_oe` are low, `req_ready` is high and `rd_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampled while low |
| strap_n | input | 1 | Mode strap: low selects three latched address bytes |
| req_valid | input | 1 | Read request |
| req_addr | input | 24 | Byte address of the request |
| acc_wait | input | 4 | Access time in clocks, minus one |
| par_en | input | 1 | Enable parity check on the returned byte |
| req_ready | output | 1 | High when a request can be accepted |
| rd_done | output | 1 | One-cycle pulse: read byte valid |
| rd_data | output | 8 | Returned byte |
| rd_perr | output | 1 | Parity error on the returned byte |
| rom_sel_n | output | 1 | Active-low EPROM select |
| ale_lo | output | 1 | Latch enable for address bits 7:0 |
| ale_mid | output | 1 | Latch enable for address bits 15:8 |
| a16_ale | output | 1 | Address bit 16, or third latch enable in three-latch mode |
| a17_pin | output | 1 | Address bit 17 |
| bus_dout | output | 8 | Data bus value driven by the block |
| bus_oe | output | 1 | Data bus output enable |
| bus_par_out | output | 1 | Odd parity of `bus_dout` |
| bus_din | input | 8 | Data bus value received |
| bus_par_in | input | 1 | Parity line received |

## Verification
The bench's EPROM model rebuilds the address from what its latches actually captured and returns a byte that depends on all three address bytes. A byte phase that is swapped or missing therefore shows up as wrong data, not only as a wrong strobe count. Addresses with alternating, all-ones and zero bytes are used to tell the byte lanes apart. Access times of 0, 3 and 15 separate an off-by-one in the wait counter from a fixed latency. Both strap settings are tried with bit 16 and bit 17 set and clear, which distinguishes the direct pins from the third enable. Parity runs with the check on and a corrupted parity line, with the check off and the same corruption, and with a request held high during a busy access. Together these separate the error flag, its enable and the busy rejection.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LAT0,
        ST_HLD0,
        ST_LAT1,
        ST_HLD1,
        ST_LAT2,
        ST_HLD2,
        ST_TURN,
        ST_WAIT,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/eprom_odd_par.sv
module eprom_odd_par #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         odd_bit
);
    // bit that makes the count of ones over data plus itself odd
    assign odd_bit = ~(^data);
endmodule

// File: rtl/eprom_strap_latch.sv
module eprom_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_n,
    output logic three_lat
);
    // follows the strap only while reset is held, frozen afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) three_lat <= ~strap_n;
    end
endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                three_lat,
    input  logic                req_valid,
    input  logic [3*DATA_W-1:0] req_addr,
    input  logic [WAIT_W-1:0]   acc_wait,
    input  logic                par_en,
    input  logic [DATA_W-1:0]   din,
    input  logic                din_perr,
    output logic                req_ready,
    output logic                rd_done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_perr,
    output logic                rom_sel_n,
    output logic                ale_lo,
    output logic                ale_mid,
    output logic                a16_ale,
    output logic                a17_pin,
    output logic [DATA_W-1:0]   dout,
    output logic                oe
);
    localparam int ADDR_W = 3 * DATA_W;
    localparam int B16    = 2 * DATA_W;
    localparam int B17    = 2 * DATA_W + 1;

    rd_state_t           state, state_nx;
    logic [ADDR_W-1:0]   addr_q;
    logic [WAIT_W-1:0]   cnt_q;
    logic                ale_hi;
    logic                wait_end;

    assign wait_end = (state == ST_WAIT) && (cnt_q == acc_wait);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_LAT0;
            ST_LAT0: state_nx = ST_HLD0;
            ST_HLD0: state_nx = ST_LAT1;
            ST_LAT1: state_nx = ST_HLD1;
            ST_HLD1: state_nx = three_lat ? ST_LAT2 : ST_TURN;
            ST_LAT2: state_nx = ST_HLD2;
            ST_HLD2: state_nx = ST_TURN;
            ST_TURN: state_nx = ST_WAIT;
            ST_WAIT: if (wait_end) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // address, wait counter and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            rd_data <= '0;
            rd_perr <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state == ST_TURN)      cnt_q <= '0;
            else if (state == ST_WAIT) cnt_q <= cnt_q + 1'b1;
            if (wait_end) begin
                rd_data <= din;
                rd_perr <= par_en & din_perr;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        rd_done   = 1'b0;
        rom_sel_n = 1'b1;
        ale_lo    = 1'b0;
        ale_mid   = 1'b0;
        ale_hi    = 1'b0;
        oe        = 1'b0;
        dout      = '0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_LAT0, ST_HLD0: begin
                rom_sel_n = 1'b0;
                oe        = 1'b1;
                ale_lo    = (state == ST_LAT0);
                dout      = addr_q[DATA_W-1:0];
            end
            ST_LAT1, ST_HLD1: begin
                rom_sel_n = 1'b0;
                oe        = 1'b1;
                ale_mid   = (state == ST_LAT1);
                dout      = addr_q[2*DATA_W-1:DATA_W];
            end
            ST_LAT2, ST_HLD2: begin
                rom_sel_n = 1'b0;
                oe        = 1'b1;
                ale_hi    = (state == ST_LAT2);
                dout      = addr_q[ADDR_W-1:2*DATA_W];
            end
            ST_TURN, ST_WAIT: rom_sel_n = 1'b0;
            ST_DONE: rd_done = 1'b1;
            default: ;
        endcase
        a16_ale = three_lat ? ale_hi : addr_q[B16];
        a17_pin = addr_q[B17];
    end

    // R1: a done pulse closes a cycle with select low
    a_r1_sel_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(!rom_sel_n));
    // R2: low-byte enable lasts one clock, byte held behind it
    a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ale_lo |=> !ale_lo && oe && $stable(dout));
    // R3: middle-byte enable lasts one clock, byte held behind it
    a_r3_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ale_mid |=> !ale_mid && oe && $stable(dout));
    // R6: bus drive starts only after a cycle with select high
    a_r6_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(rom_sel_n));
    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
endmodule

// File: rtl/eprom_mux_reader.sv
module eprom_mux_reader #(
    parameter int DATA_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_n,
    input  logic                req_valid,
    input  logic [3*DATA_W-1:0] req_addr,
    input  logic [WAIT_W-1:0]   acc_wait,
    input  logic                par_en,
    output logic                req_ready,
    output logic                rd_done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_perr,
    output logic                rom_sel_n,
    output logic                ale_lo,
    output logic                ale_mid,
    output logic                a16_ale,
    output logic                a17_pin,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_oe,
    output logic                bus_par_out,
    input  logic [DATA_W-1:0]   bus_din,
    input  logic                bus_par_in
);
    logic three_lat;
    logic din_odd;
    logic din_perr;

    eprom_strap_latch u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_n   (strap_n),
        .three_lat (three_lat)
    );

    eprom_odd_par #(.W(DATA_W)) u_par_gen (
        .data    (bus_dout),
        .odd_bit (bus_par_out)
    );

    eprom_odd_par #(.W(DATA_W)) u_par_chk (
        .data    (bus_din),
        .odd_bit (din_odd)
    );

    assign din_perr = din_odd ^ bus_par_in;

    eprom_rd_seq #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .three_lat (three_lat),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .acc_wait  (acc_wait),
        .par_en    (par_en),
        .din       (bus_din),
        .din_perr  (din_perr),
        .req_ready (req_ready),
        .rd_done   (rd_done),
        .rd_data   (rd_data),
        .rd_perr   (rd_perr),
        .rom_sel_n (rom_sel_n),
        .ale_lo    (ale_lo),
        .ale_mid   (ale_mid),
        .a16_ale   (a16_ale),
        .a17_pin   (a17_pin),
        .dout      (bus_dout),
        .oe        (bus_oe)
    );

    // R8: parity driven with every address byte is odd
    a_r8_par_odd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ^{bus_dout, bus_par_out});
endmodule

// File: tb/eprom_mux_reader_bench.sv
`timescale 1ns/1ps
module eprom_mux_reader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  acc_wait = '0;
    logic        par_en = 1'b0;
    logic        req_ready, rd_done, rd_perr, rom_sel_n;
    logic        ale_lo, ale_mid, a16_ale, a17_pin;
    logic [7:0]  rd_data, bus_dout, bus_din;
    logic        bus_oe, bus_par_out, bus_par_in;

    int errors = 0;
    int checks = 0;
    bit bmode3 = 1'b1;
    bit bad_par = 1'b0;
    logic [7:0] lat0 = '0, lat1 = '0, lat2 = '0;
    int cnt_lo, cnt_mid, cnt_hi, cnt_sel, cnt_oe;
    bit a16_seen0, a16_seen1, a17_seen0, a17_seen1;
    logic prev_lo = 1'b0, prev_mid = 1'b0;
    logic [7:0] prev_dout = '0;

    always #2.5 clk = ~clk;

    eprom_mux_reader u_eprom_mux_reader (
        .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .req_valid(req_valid),
        .req_addr(req_addr), .acc_wait(acc_wait), .par_en(par_en),
        .req_ready(req_ready), .rd_done(rd_done), .rd_data(rd_data),
        .rd_perr(rd_perr), .rom_sel_n(rom_sel_n), .ale_lo(ale_lo),
        .ale_mid(ale_mid), .a16_ale(a16_ale), .a17_pin(a17_pin),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_par_out(bus_par_out),
        .bus_din(bus_din), .bus_par_in(bus_par_in)
    );

    function automatic logic [7:0] rom_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[22:16], a[23]} ^ 8'hA5;
    endfunction

    function automatic logic [23:0] model_addr();
        return bmode3 ? {lat2, lat1, lat0} : {6'b0, a17_pin, a16_ale, lat1, lat0};
    endfunction

    // external latches and EPROM model
    always @(negedge ale_lo)  lat0 = bus_dout;
    always @(negedge ale_mid) lat1 = bus_dout;
    always @(negedge a16_ale) if (bmode3) lat2 = bus_dout;

    assign bus_din    = (!rom_sel_n && !bus_oe) ? rom_byte(model_addr()) : 8'hFF;
    assign bus_par_in = (~(^bus_din)) ^ bad_par;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle monitor, sampling between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale_lo) cnt_lo++;
            if (ale_mid) cnt_mid++;
            if (bmode3 && a16_ale) cnt_hi++;
            if (!rom_sel_n) begin
                cnt_sel++;
                if (a16_ale) a16_seen1 = 1'b1; else a16_seen0 = 1'b1;
                if (a17_pin) a17_seen1 = 1'b1; else a17_seen0 = 1'b1;
            end
            if (bus_oe) begin
                cnt_oe++;
                check(bus_par_out == ~(^bus_dout), "R8", "address parity",
                      bus_par_out, ~(^bus_dout));
            end
            if (prev_lo)
                check(!ale_lo && bus_oe && bus_dout == prev_dout, "R2",
                      "low byte hold", bus_dout, prev_dout);
            if (prev_mid)
                check(!ale_mid && bus_oe && bus_dout == prev_dout, "R3",
                      "mid byte hold", bus_dout, prev_dout);
            prev_lo   = ale_lo;
            prev_mid  = ale_mid;
            prev_dout = bus_dout;
        end
    end

    task automatic apply_reset(input bit strap);
        rst_n   = 1'b0;
        strap_n = strap;
        bmode3  = !strap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic test_reset_state();
        check(rom_sel_n === 1'b1, "R12", "select idle", rom_sel_n, 1);
        check({ale_lo, ale_mid, bus_oe} === 3'b000, "R12", "enables idle",
              {ale_lo, ale_mid, bus_oe}, 0);
        check(req_ready === 1'b1 && rd_done === 1'b0, "R12", "ready/done",
              {req_ready, rd_done}, 2);
    endtask

    task automatic do_read(input logic [23:0] a, input logic [3:0] w,
                           input bit pe, input bit bp, input bit poke);
        int lat;
        int exp_lat;
        logic [23:0] exp_a;
        acc_wait = w;
        par_en   = pe;
        bad_par  = bp;
        @(negedge clk);
        #1;
        cnt_lo = 0; cnt_mid = 0; cnt_hi = 0; cnt_sel = 0; cnt_oe = 0;
        a16_seen0 = 0; a16_seen1 = 0; a17_seen0 = 0; a17_seen1 = 0;
        check(req_ready === 1'b1, "R10", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        lat = 0;
        do begin
            @(negedge clk);
            #1;
            lat++;
            req_valid = poke && lat < 4;
            if (poke) req_addr = ~a;
            if (lat > 1 && lat < 4 && poke)
                check(req_ready === 1'b0, "R10", "ready low while busy", req_ready, 0);
        end while (!rd_done && lat < 100);
        req_valid = 1'b0;
        exp_lat = bmode3 ? int'(w) + 9 : int'(w) + 7;
        exp_a   = bmode3 ? a : {6'b0, a[17:0]};
        check(lat == exp_lat, bmode3 ? "R4" : "R5", "done latency", lat, exp_lat);
        check(model_addr() == exp_a, bmode3 ? "R4" : "R5", "latched address",
              model_addr(), exp_a);
        check(rd_data == rom_byte(exp_a), poke ? "R11" : "R10", "read byte",
              rd_data, rom_byte(exp_a));
        check(rd_perr == (pe & bp), "R9", "parity flag", rd_perr, pe & bp);
        check(cnt_lo == 1, poke ? "R11" : "R2", "low enable pulses", cnt_lo, 1);
        check(cnt_mid == 1, "R3", "mid enable pulses", cnt_mid, 1);
        check(cnt_hi == (bmode3 ? 1 : 0), bmode3 ? "R4" : "R5", "third enable pulses",
              cnt_hi, bmode3 ? 1 : 0);
        check(cnt_oe == (bmode3 ? 6 : 4), "R6", "bus drive cycles", cnt_oe,
              bmode3 ? 6 : 4);
        check(cnt_sel == lat - 1 && rom_sel_n, "R1", "select low cycles",
              cnt_sel, lat - 1);
        if (!bmode3) begin
            check(!(a16_seen0 && a16_seen1) && (a16_seen1 == a[16]), "R5",
                  "bit16 pin steady", a16_seen1, a[16]);
        end
        check(!(a17_seen0 && a17_seen1) && (a17_seen1 == a[17]), "R7",
              "bit17 pin steady", a17_seen1, a[17]);
        @(negedge clk);
        #1;
        check(rd_done === 1'b0 && req_ready === 1'b1, "R10", "done single pulse",
              {rd_done, req_ready}, 1);
    endtask

    task automatic test_three_latch();
        do_read(24'hA5_3C_0F, 4'd0, 1'b0, 1'b0, 1'b0);
        do_read(24'h12_34_56, 4'd3, 1'b0, 1'b0, 1'b0);
        do_read(24'hFF_FF_FF, 4'd15, 1'b0, 1'b0, 1'b0);
        do_read(24'h00_00_00, 4'd1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_parity();
        do_read(24'h5A_81_7E, 4'd2, 1'b1, 1'b0, 1'b0);
        do_read(24'h5A_81_7E, 4'd2, 1'b1, 1'b1, 1'b0);
        do_read(24'h03_C0_33, 4'd2, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_busy();
        do_read(24'h6B_2D_91, 4'd4, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_two_latch();
        do_read(24'hFE_AA_55, 4'd0, 1'b0, 1'b0, 1'b0);
        do_read(24'h01_F0_0F, 4'd5, 1'b1, 1'b0, 1'b0);
        do_read(24'h02_12_34, 4'd15, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        apply_reset(1'b0);
        test_reset_state();
        test_three_latch();
        test_parity();
        test_busy();
        apply_reset(1'b1);
        test_reset_state();
        test_two_latch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule